// File: doc/BRIEF.md
# Block-Start Indexed Next-Fetch Predictor

This block predicts the fetch path one basic block at a time. Its table is looked up with the address of the first instruction of a basic block. Each lookup returns the predicted start address of the following basic block. That result is written back into the lookup register, so a new prediction can be formed every cycle. The prediction loop never waits for the instruction-fetch unit or for decode, so the wire delay between the predictor and fetch is not part of that loop.

Each predicted block start is pushed into a small FIFO that sits in front of the fetch unit. The fetch unit steps through sequential cache lines by itself. When it signals that it has met a control instruction, it takes the head of the FIFO as its next fetch address, and that address also becomes the current block start. The fetch unit can record the current block start with each branch. When the branch resolves, the execution stage writes the true successor back into the table under that same block-start address. A misprediction redirect flushes the FIFO and restarts both the predictor and fetch at the corrected block start.

Top module: `bb_next_fetch_pred`

## Requirements
- R1: While `rst_n` is low and just after it is released, `q_valid` and `fetch_stall` are 0, and `fetch_addr` and `fetch_blk` both equal parameter `RESET_ADDR` (default 0).
- R2: The table is direct-mapped. The entry index is the low `IDX_W` bits (default 4) of a block-start address, and the tag is the remaining upper bits. On a hit, the stored successor is pushed into the FIFO and becomes the next lookup address, so consecutive FIFO entries follow the trained chain.
- R3: On a miss (the entry is invalid or its tag differs), the prediction is the start of the next cache line: the address with its low `$clog2(LINE_WORDS)` bits cleared (default 3), plus `LINE_WORDS` (default 8).
- R4: A cycle with `upd_valid` high writes `upd_target` as the successor of `upd_blk`. The write fills an empty entry or replaces any entry already at that index. Two entry addresses of the same block that have different index bits keep separate entries.
- R5: The FIFO (depth `Q_DEPTH`, default 4) hands out predictions in the order they were made. When it is full, the predictor pushes nothing and holds its lookup address, so no prediction is lost or skipped.
- R6: In the cycle after `redir_valid` is high, the FIFO is empty, and `fetch_addr` and `fetch_blk` both equal `redir_addr`. The first prediction, made from `redir_addr`, is at the FIFO head one cycle later.
- R7: When `ctl_seen` is high and `q_valid` is high, in the next cycle `fetch_addr` and `fetch_blk` both equal the former head, and the head has advanced to the following prediction.
- R8: When `ctl_seen` and `redir_valid` are both low, `fetch_addr` advances in each cycle to the start of the next cache line, using the line arithmetic of R3.
- R9: When `ctl_seen` is high, `q_valid` is low and `redir_valid` is low, `fetch_stall` is 1 and `fetch_addr` holds its value into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| redir_valid | input | 1 | Misprediction redirect from execution |
| redir_addr | input | ADDR_W | Corrected block-start address |
| upd_valid | input | 1 | Table training write |
| upd_blk | input | ADDR_W | Block-start address that indexes the entry being trained |
| upd_target | input | ADDR_W | Resolved start address of the next block |
| ctl_seen | input | 1 | Fetch has met a control instruction |
| q_valid | output | 1 | FIFO holds at least one prediction |
| q_addr | output | ADDR_W | Oldest queued block-start prediction |
| fetch_addr | output | ADDR_W | Current fetch address |
| fetch_blk | output | ADDR_W | Start address of the block being fetched |
| fetch_stall | output | 1 | Fetch is waiting on an empty FIFO |

## Verification
A redirect shows on `fetch_addr` and `fetch_blk` one rising edge after it is applied. The first prediction reaches the FIFO head on the edge after that, and each later edge adds one more prediction until the FIFO is full. An adopted head, and each sequential line step, shows on `fetch_addr` one edge after `ctl_seen` (or its absence) is sampled. `fetch_stall` is combinational and is valid in the same cycle as `ctl_seen`. The bench changes inputs on falling edges and reads outputs on the next falling edge, so each check sees the state after exactly the counted number of rising edges.

// File: rtl/bbnf_pkg.sv
package bbnf_pkg;
  // Where the next fetch address comes from
  typedef enum logic [1:0] {
    FS_SEQ   = 2'd0,
    FS_QUEUE = 2'd1,
    FS_HOLD  = 2'd2,
    FS_REDIR = 2'd3
  } fetch_src_e;
endpackage

// File: rtl/bbnf_table.sv
module bbnf_table #(
  parameter int ADDR_W = 16,
  parameter int IDX_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              rd_hit,
  output logic [ADDR_W-1:0] rd_data,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [ADDR_W-1:0] wr_data
);
  localparam int ENTRIES = 1 << IDX_W;
  localparam int TAG_W   = ADDR_W - IDX_W;

  function automatic logic [IDX_W-1:0] idx_of(input logic [ADDR_W-1:0] a);
    return a[IDX_W-1:0];
  endfunction

  function automatic logic [TAG_W-1:0] tag_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:IDX_W];
  endfunction

  logic [ENTRIES-1:0] ent_vld;
  logic [TAG_W-1:0]   ent_tag [ENTRIES];
  logic [ADDR_W-1:0]  ent_tgt [ENTRIES];

  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    wire sel_wr = wr_en && (idx_of(wr_addr) == IDX_W'(e));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ent_vld[e] <= 1'b0;
      else if (sel_wr) ent_vld[e] <= 1'b1;
    end
    always_ff @(posedge clk) begin
      if (sel_wr) begin
        ent_tag[e] <= tag_of(wr_addr);
        ent_tgt[e] <= wr_data;
      end
    end
  end

  wire [IDX_W-1:0] rd_idx = idx_of(rd_addr);
  assign rd_hit  = ent_vld[rd_idx] && (ent_tag[rd_idx] == tag_of(rd_addr));
  assign rd_data = ent_tgt[rd_idx];

  // A trained entry reads back as a hit for the trained address in the next cycle
  AST_TRAIN_HITS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && rd_addr == wr_addr && $stable(rd_addr)) |=> (rd_hit || $past(rd_addr) != rd_addr)) else $error("table"); // R4
endmodule

// File: rtl/bbnf_queue.sv
module bbnf_queue #(
  parameter int W     = 16,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         flush,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  output logic         head_valid,
  output logic [W-1:0] head,
  output logic         full
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_LAST) ? '0 : p + PTR_W'(1);
  endfunction

  logic [W-1:0]     slot [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] cnt;

  assign full       = (cnt == CNT_FULL);
  assign head_valid = (cnt != '0);
  assign head       = slot[rd_ptr];

  wire do_push = push && !full && !flush;
  wire do_pop  = pop && head_valid && !flush;

  always_ff @(posedge clk) begin
    if (do_push) slot[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (do_push) wr_ptr <= ptr_inc(wr_ptr);
      if (do_pop)  rd_ptr <= ptr_inc(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + CNT_W'(1);
        2'b01:   cnt <= cnt - CNT_W'(1);
        default: cnt <= cnt;
      endcase
    end
  end

  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !head_valid) else $error("flush"); // R6
  AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !pop && !flush) |=> full) else $error("full"); // R5
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_FULL) else $error("overflow"); // R5
endmodule

// File: rtl/bb_next_fetch_pred.sv
module bb_next_fetch_pred
  import bbnf_pkg::*;
#(
  parameter int          ADDR_W     = 16,
  parameter int          IDX_W      = 4,
  parameter int          Q_DEPTH    = 4,
  parameter int          LINE_WORDS = 8,
  parameter logic [15:0] RESET_ADDR = 16'h0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              redir_valid,
  input  logic [ADDR_W-1:0] redir_addr,
  input  logic              upd_valid,
  input  logic [ADDR_W-1:0] upd_blk,
  input  logic [ADDR_W-1:0] upd_target,
  input  logic              ctl_seen,
  output logic              q_valid,
  output logic [ADDR_W-1:0] q_addr,
  output logic [ADDR_W-1:0] fetch_addr,
  output logic [ADDR_W-1:0] fetch_blk,
  output logic              fetch_stall
);
  localparam int OFF_W = $clog2(LINE_WORDS);
  localparam logic [ADDR_W-1:0] RST_A = ADDR_W'(RESET_ADDR);

  // Start of the cache line after the one holding a
  function automatic logic [ADDR_W-1:0] next_line(input logic [ADDR_W-1:0] a);
    logic [ADDR_W-1:0] base;
    base = (a >> OFF_W) + ADDR_W'(1);
    return base << OFF_W;
  endfunction

  // Predictor loop
  logic [ADDR_W-1:0] pred_pc;
  logic              tbl_hit;
  logic [ADDR_W-1:0] tbl_tgt;
  logic              q_full;

  bbnf_table #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_table (
    .clk(clk), .rst_n(rst_n),
    .rd_addr(pred_pc), .rd_hit(tbl_hit), .rd_data(tbl_tgt),
    .wr_en(upd_valid), .wr_addr(upd_blk), .wr_data(upd_target)
  );

  wire [ADDR_W-1:0] pred_next = tbl_hit ? tbl_tgt : next_line(pred_pc);
  wire              pred_push = !q_full && !redir_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           pred_pc <= RST_A;
    else if (redir_valid) pred_pc <= redir_addr;
    else if (pred_push)   pred_pc <= pred_next;
  end

  // Fetch-side selection
  fetch_src_e fsrc;
  always_comb begin
    if (redir_valid)   fsrc = FS_REDIR;
    else if (!ctl_seen) fsrc = FS_SEQ;
    else if (q_valid)  fsrc = FS_QUEUE;
    else               fsrc = FS_HOLD;
  end

  wire q_pop = (fsrc == FS_QUEUE);
  assign fetch_stall = (fsrc == FS_HOLD);

  bbnf_queue #(.W(ADDR_W), .DEPTH(Q_DEPTH)) u_queue (
    .clk(clk), .rst_n(rst_n), .flush(redir_valid),
    .push(pred_push), .push_data(pred_next), .pop(q_pop),
    .head_valid(q_valid), .head(q_addr), .full(q_full)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fetch_addr <= RST_A;
      fetch_blk  <= RST_A;
    end else begin
      case (fsrc)
        FS_REDIR: begin
          fetch_addr <= redir_addr;
          fetch_blk  <= redir_addr;
        end
        FS_QUEUE: begin
          fetch_addr <= q_addr;
          fetch_blk  <= q_addr;
        end
        FS_SEQ:  fetch_addr <= next_line(fetch_addr);
        default: fetch_addr <= fetch_addr;
      endcase
    end
  end

  AST_REDIR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    redir_valid |=> (fetch_addr == $past(redir_addr) && !q_valid)) else $error("redir"); // R6
  AST_ADOPT_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
    q_pop |=> (fetch_addr == $past(q_addr) && fetch_blk == $past(q_addr))) else $error("adopt"); // R7
  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_stall |=> $stable(fetch_addr)) else $error("stall"); // R9
  AST_PRED_WAITS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (q_full && !redir_valid) |=> $stable(pred_pc)) else $error("pred"); // R5
endmodule

// File: tb/bb_next_fetch_pred_tb.sv
`timescale 1ns/1ps
module bb_next_fetch_pred_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        redir_valid = 1'b0;
  logic [15:0] redir_addr = '0;
  logic        upd_valid = 1'b0;
  logic [15:0] upd_blk = '0;
  logic [15:0] upd_target = '0;
  logic        ctl_seen = 1'b0;
  logic        q_valid;
  logic [15:0] q_addr;
  logic [15:0] fetch_addr;
  logic [15:0] fetch_blk;
  logic        fetch_stall;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  bb_next_fetch_pred dut_i (
    .clk(clk), .rst_n(rst_n),
    .redir_valid(redir_valid), .redir_addr(redir_addr),
    .upd_valid(upd_valid), .upd_blk(upd_blk), .upd_target(upd_target),
    .ctl_seen(ctl_seen),
    .q_valid(q_valid), .q_addr(q_addr),
    .fetch_addr(fetch_addr), .fetch_blk(fetch_blk), .fetch_stall(fetch_stall)
  );

  // Next line start with 8-word lines
  function automatic logic [15:0] line_after(input logic [15:0] a);
    return 16'((int'(a) / 8) * 8 + 8);
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic train(input logic [15:0] blk, input logic [15:0] tgt);
    upd_valid = 1'b1; upd_blk = blk; upd_target = tgt;
    @(negedge clk);
    upd_valid = 1'b0;
  endtask

  task automatic redirect(input logic [15:0] a);
    redir_valid = 1'b1; redir_addr = a;
    @(negedge clk);
    redir_valid = 1'b0;
  endtask

  // Redirect to start, then walk the first three predictions
  task automatic run_vec(input logic [15:0] start, input logic [15:0] e0,
                         input logic [15:0] e1, input logic [15:0] e2);
    logic [15:0] exp_q [3];
    exp_q[0] = e0; exp_q[1] = e1; exp_q[2] = e2;
    redirect(start);
    check("R6 queue flushed", {15'd0, q_valid}, 16'd0);
    check("R6 fetch_addr", fetch_addr, start);
    check("R6 fetch_blk", fetch_blk, start);
    @(negedge clk);
    check("R8 sequential line", fetch_addr, line_after(start));
    check("R2 first prediction valid", {15'd0, q_valid}, 16'd1);
    check("R2 first prediction", q_addr, e0);
    repeat (6) @(negedge clk);
    for (int k = 0; k < 3; k++) begin
      check("R5 queue order", q_addr, exp_q[k]);
      ctl_seen = 1'b1;
      @(negedge clk);
      check("R7 fetch adopts head", fetch_addr, exp_q[k]);
      check("R7 block start", fetch_blk, exp_q[k]);
    end
    ctl_seen = 1'b0;
  endtask

  // {start, pred0, pred1, pred2}
  localparam logic [63:0] VEC [4] = '{
    64'h0100_0234_0051_0100,   // R2 trained loop
    64'h0053_0900_0908_0910,   // R4 second entry point, R3 tag mismatch
    64'h1005_1008_1010_1018,   // R3 invalid entry and tag mismatch
    64'h0051_0100_0234_0051    // R4 first entry point kept separate
  };

  initial begin
    repeat (3) @(negedge clk);
    check("R1 q_valid in reset", {15'd0, q_valid}, 16'd0);
    check("R1 fetch_addr in reset", fetch_addr, 16'h0000);
    check("R1 fetch_blk in reset", fetch_blk, 16'h0000);
    check("R1 stall in reset", {15'd0, fetch_stall}, 16'd0);
    rst_n = 1'b1;
    #1;
    check("R1 q_valid after release", {15'd0, q_valid}, 16'd0);

    train(16'h0100, 16'h0234);
    train(16'h0234, 16'h0051);
    train(16'h0051, 16'h0100);
    train(16'h0053, 16'h0900);

    for (int v = 0; v < 4; v++)
      run_vec(VEC[v][63:48], VEC[v][47:32], VEC[v][31:16], VEC[v][15:0]);

    // R9: control instruction met on an empty queue
    redirect(16'h0234);
    ctl_seen = 1'b1;
    #1;
    check("R9 stall on empty queue", {15'd0, fetch_stall}, 16'd1);
    @(negedge clk);
    check("R9 fetch holds", fetch_addr, 16'h0234);
    @(negedge clk);
    check("R7 adopt after stall", fetch_addr, 16'h0051);
    ctl_seen = 1'b0;

    // R4: overwrite index 0 with another block
    train(16'h0A00, 16'h0300);
    run_vec(16'h0100, 16'h0108, 16'h0110, 16'h0118);
    run_vec(16'h0A00, 16'h0300, 16'h0308, 16'h0310);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule